// File: doc/BRIEF.md
# Signed 32-by-16 Iterative Divider with Fault Flags

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It returns a 16-bit quotient, a 16-bit remainder and four condition flags (N, Z, V, C). The dividend comes from a register pair. The word from the even-numbered register is the upper half. The word from the register whose number is the even number OR 1 is the lower half. The caller gives both halves and the divisor, then pulses `start_i`. The result arrives with a single-cycle `done_o`.

The quotient is computed on magnitudes with a restoring shift-and-subtract loop, one quotient bit per cycle, and the signs are applied afterwards. Three faults are reported:
- a zero divisor;
- the most negative dividend divided by minus one;
- a quotient too wide for 16 bits.

The first two are caught as soon as the operands are accepted. The third is found once the loop ends. On any fault both register write enables stay low, so the register pair keeps its old contents.

Top module: `sdiv_top`

## Requirements
- R1: The dividend is the signed 32-bit value {`dvd_hi_i`, `dvd_lo_i`}, where `dvd_hi_i` is the even register's word and `dvd_lo_i` is the odd register's word. The divisor `dvs_i` is a signed 16-bit value.
- R2: A zero divisor produces `flags_o` = 4'b0011 (bit order N,Z,V,C from bit 3 down to bit 0, so V=1 and C=1). Both write enables stay low, and `done_o` rises in the cycle right after the accepting edge.
- R3: A dividend of -2^31 with a divisor of -1 produces `flags_o` = 4'b0010 (V only). Both write enables stay low, and `done_o` rises in the cycle right after the accepting edge, before any iteration.
- R4: A true quotient outside -32768..+32767 produces `flags_o` = 4'b0010 (V only), and both write enables stay low.
- R5: On success, `quot_o` holds the truncated quotient and is meant for the even register. `rem_o` holds dividend minus divisor times quotient, which has the dividend's sign, and is meant for the odd register. `wr_even_o` and `wr_odd_o` are both high.
- R6: On success, N is bit 15 of the quotient and Z is 1 exactly when the quotient is zero. V and C are 0.
- R7: A division that is not caught at acceptance gives `done_o` 33 cycles after the accepting edge. `busy_o` stays high from the accepting edge until that cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The operation in flight finishes with its own operands.
- R9: `done_o` lasts one cycle per operation. The write enables are high only together with `done_o`.
- R10: While reset is asserted and after it is released, `busy_o`, `done_o`, `wr_even_o` and `wr_odd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division (taken only when idle) |
| dvd_hi_i | input | 16 | Upper dividend word (even register) |
| dvd_lo_i | input | 16 | Lower dividend word (odd register) |
| dvs_i | input | 16 | Signed divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Signed quotient |
| rem_o | output | 16 | Signed remainder |
| flags_o | output | 4 | {N,Z,V,C} |
| wr_even_o | output | 1 | Write quotient to even register |
| wr_odd_o | output | 1 | Write remainder to odd register |

## Verification
The hardest cases to reach are the edges of the quotient range. A quotient of exactly -32768 is legal, while +32768 must fault. Uniform random operands almost never land on that boundary, because most random 32-bit dividends overflow a 16-bit quotient. The stimulus therefore builds most dividends as a chosen 16-bit quotient times the divisor plus a small offset. It also adds directed cases at ±32767, ±32768 and 65535/65536 divided by ±1 and ±2, next to the two early faults. One operation also gets a second start pulse mid-run to show that it is ignored.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sdiv_flags_t;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output logic           q_neg_o,
  output logic           r_neg_o,
  output logic           dvs_zero_o,
  output logic           min_by_m1_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] DVD_MIN = DW'(1) << (DW - 1);

  logic [DW-1:0] dvd;
  logic          dvd_s;
  logic          dvs_s;

  always_comb begin
    dvd         = {hi_i, lo_i};
    dvd_s       = dvd[DW-1];
    dvs_s       = dvs_i[W-1];
    dvd_mag_o   = dvd_s ? (DW'(0) - dvd) : dvd;
    dvs_mag_o   = dvs_s ? (W'(0) - dvs_i) : dvs_i;
    q_neg_o     = dvd_s ^ dvs_s;
    r_neg_o     = dvd_s;
    dvs_zero_o  = (dvs_i == '0);
    min_by_m1_o = (dvd == DVD_MIN) && (dvs_i == '1);
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_mag_i,
  input  logic [W-1:0]   dvs_mag_i,
  output logic [2*W-1:0] quo_mag_o,
  output logic [W:0]     rem_mag_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] quo_q, quo_d;
  logic [W:0]    rem_q, rem_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W:0]    rem_sh;
  logic          fits;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[DW-1]};
    fits   = (rem_sh >= {1'b0, dvs_q});
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    if (load_i) begin
      quo_d = dvd_mag_i;
      rem_d = '0;
      dvs_d = dvs_mag_i;
    end else if (step_i) begin
      rem_d = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
      quo_d = {quo_q[DW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_mag_o = quo_q;
  assign rem_mag_o = rem_q;
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] quo_mag_i,
  input  logic [W:0]     rem_mag_i,
  input  logic           q_neg_i,
  input  logic           r_neg_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           ovf_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] NEG_LIM = DW'(1) << (W - 1);
  localparam logic [DW-1:0] POS_LIM = NEG_LIM - DW'(1);

  always_comb begin
    ovf_o = q_neg_i ? (quo_mag_i > NEG_LIM) : (quo_mag_i > POS_LIM);
    quo_o = q_neg_i ? (W'(0) - quo_mag_i[W-1:0]) : quo_mag_i[W-1:0];
    rem_o = r_neg_i ? (W'(0) - rem_mag_i[W-1:0]) : rem_mag_i[W-1:0];
  end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic [3:0]   flags_o,
  output logic         wr_even_o,
  output logic         wr_odd_o
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] dvd_mag, quo_mag;
  logic [W-1:0]  dvs_mag, quo_fix, rem_fix;
  logic [W:0]    rem_mag;
  logic          q_neg_in, r_neg_in, dvs_zero, min_by_m1, ovf;

  sdiv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_neg_q, r_neg_q;
  logic          load, step, fin, early;

  logic          done_q, done_d, wr_q, wr_d;
  sdiv_flags_t   flg_q, flg_d;
  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d;

  sdiv_prep #(.W(W)) u_prep (
    .hi_i(dvd_hi_i), .lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .dvd_mag_o(dvd_mag), .dvs_mag_o(dvs_mag),
    .q_neg_o(q_neg_in), .r_neg_o(r_neg_in),
    .dvs_zero_o(dvs_zero), .min_by_m1_o(min_by_m1)
  );

  sdiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .dvd_mag_i(dvd_mag), .dvs_mag_i(dvs_mag),
    .quo_mag_o(quo_mag), .rem_mag_o(rem_mag)
  );

  sdiv_fix #(.W(W)) u_fix (
    .quo_mag_i(quo_mag), .rem_mag_i(rem_mag),
    .q_neg_i(q_neg_q), .r_neg_i(r_neg_q),
    .quo_o(quo_fix), .rem_o(rem_fix), .ovf_o(ovf)
  );

  // sequencing
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    early   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (dvs_zero || min_by_m1) begin
          early = 1'b1;
        end else begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // result selection
  always_comb begin
    done_d = early || fin;
    wr_d   = 1'b0;
    flg_d  = flg_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    if (early) begin
      flg_d = '{n: 1'b0, z: 1'b0, v: 1'b1, c: dvs_zero};
    end else if (fin) begin
      if (ovf) begin
        flg_d = '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
      end else begin
        flg_d = '{n: quo_fix[W-1], z: (quo_fix == '0), v: 1'b0, c: 1'b0};
        quo_d = quo_fix;
        rem_d = rem_fix;
        wr_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      q_neg_q <= 1'b0;
      r_neg_q <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      flg_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      wr_q    <= wr_d;
      if (load) begin
        q_neg_q <= q_neg_in;
        r_neg_q <= r_neg_in;
      end
      if (done_d) begin
        flg_q <= flg_d;
        quo_q <= quo_d;
        rem_q <= rem_d;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign wr_even_o = wr_q;
  assign wr_odd_o  = wr_q;
  assign quot_o    = quo_q;
  assign rem_o     = rem_q;
  assign flags_o   = flg_q;
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [3:0] flags_o,
  input logic       wr_even_o,
  input logic       wr_odd_o
);
  AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_even_o |-> done_o); // R9
  AST_WR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_even_o == wr_odd_o); // R5
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && flags_o[1]) |-> !wr_even_o); // R4
  AST_OK_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_even_o |-> (!flags_o[1] && !flags_o[0])); // R6
  AST_CARRY_IMPLIES_V: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && flags_o[0]) |-> (flags_o[1] && !wr_even_o)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !done_o && !wr_even_o)); // R10
endmodule

bind sdiv_top sdiv_checker u_sdiv_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .flags_o(flags_o), .wr_even_o(wr_even_o),
  .wr_odd_o(wr_odd_o)
);

// File: tb/tb_sdiv_top.sv
module tb_sdiv_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] dvd_hi_i, dvd_lo_i, dvs_i;
  logic        busy_o, done_o, wr_even_o, wr_odd_o;
  logic [15:0] quot_o, rem_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  sdiv_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
    .flags_o(flags_o), .wr_even_o(wr_even_o), .wr_odd_o(wr_odd_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // behavioural reference for one operation, compared on every clock
  task automatic run_op(input logic [15:0] hi, input logic [15:0] lo,
                        input logic [15:0] dv, input bit inject);
    longint dvd, dvl, q, r;
    bit     early, fault, zero;
    logic [3:0] ef;
    int     kexp;
    dvd  = longint'($signed({hi, lo}));
    dvl  = longint'($signed(dv));
    zero = (dvl == 0);
    early = zero || (dvd == -64'sd2147483648 && dvl == -1);
    fault = early;
    q = 0; r = 0;
    if (!early) begin
      q = dvd / dvl;
      r = dvd - dvl * q;
      if (q > 32767 || q < -32768) fault = 1;
    end
    if (zero) ef = 4'b0011;
    else if (fault) ef = 4'b0010;
    else ef = {q[15], (q == 0), 2'b00};
    kexp = early ? 1 : 34;

    @(negedge clk);
    chk(!busy_o, "R8 idle before start", busy_o, 0);
    start_i = 1'b1; dvd_hi_i = hi; dvd_lo_i = lo; dvs_i = dv;
    for (int k = 1; k <= kexp; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (k < kexp) begin
        chk(!done_o, "R7 done early", done_o, 0);
        chk(busy_o, "R7 busy during run", busy_o, 1);
        if (inject && k == 5) begin
          start_i = 1'b1; dvd_hi_i = 16'h0000; dvd_lo_i = 16'h0007; dvs_i = 16'h0000;
        end
        if (inject && k == 6) start_i = 1'b0;
      end else begin
        chk(done_o, early ? "R2/R3 done timing" : "R7 done timing", done_o, 1);
        chk(flags_o == ef, zero ? "R2 flags" : (early ? "R3 flags" : (fault ? "R4 flags" : "R6 flags")),
            flags_o, ef);
        chk(wr_even_o == !fault && wr_odd_o == !fault,
            fault ? "R4 write suppressed" : "R5 write enables", wr_even_o, !fault);
        if (!fault) begin
          chk(quot_o == q[15:0], "R5 quotient R1", quot_o, q[15:0]);
          chk(rem_o == r[15:0], "R5 remainder", rem_o, r[15:0]);
        end
      end
    end
    @(negedge clk);
    chk(!done_o && !wr_even_o, "R9 single-cycle done", done_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    dvd_hi_i = '0; dvd_lo_i = '0; dvs_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !wr_even_o && !wr_odd_o, "R10 in reset", {busy_o, done_o, wr_even_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !wr_even_o, "R10 after reset", {busy_o, done_o, wr_even_o}, 0);

    run_op(16'h0000, 16'd100, 16'd7, 0);        // R5 basic
    run_op(16'hFFFF, 16'hFF9C, 16'd7, 0);       // R5 negative dividend
    run_op(16'h0000, 16'd100, 16'hFFF9, 0);     // R6 negative quotient
    run_op(16'h0000, 16'd3, 16'd7, 0);          // R6 zero quotient
    run_op(16'h1234, 16'h5678, 16'h0000, 0);    // R2
    run_op(16'h8000, 16'h0000, 16'hFFFF, 0);    // R3
    run_op(16'h0000, 16'h7FFF, 16'd1, 0);       // R4 edge ok
    run_op(16'h0000, 16'h8000, 16'd1, 0);       // R4 overflow
    run_op(16'hFFFF, 16'h8000, 16'd1, 0);       // R4 -32768 ok
    run_op(16'h0000, 16'h8000, 16'hFFFF, 0);    // R4 -32768 ok
    run_op(16'hFFFF, 16'h7FFF, 16'd1, 0);       // R4 under
    run_op(16'h0000, 16'hFFFF, 16'd2, 0);       // R4 32767 r1
    run_op(16'h0001, 16'h0000, 16'd2, 0);       // R4 overflow
    run_op(16'h8000, 16'h0000, 16'd1, 0);       // R4 big overflow
    run_op(16'h0001, 16'h0000, 16'hFFFE, 0);    // R4 -32768 ok
    run_op(16'h0000, 16'd500, 16'd9, 1);        // R8 ignored start
    run_op(16'h0000, 16'h0000, 16'hFFFF, 0);    // R6 zero result

    for (int i = 0; i < 300; i++) begin
      logic [15:0] dv;
      logic [31:0] dd;
      int qq, rr;
      dv = 16'($urandom);
      if ((i % 37) == 0) dv = 16'h0000;
      if ((i % 4) == 0) begin
        dd = $urandom;
      end else begin
        qq = int'($signed(16'($urandom)));
        rr = int'($urandom_range(0, 50)) - 25;
        dd = 32'(qq * int'($signed(dv)) + rr);
      end
      run_op(dd[31:16], dd[15:0], dv, (i % 50) == 3); // R1 R5 random
    end
    finish_run();
  end
endmodule